// File: doc/BRIEF.md
# Decimal Carry-Lookahead BCD Adder

This block adds two packed BCD operands of a configurable number of decimal digits, plus a one-bit decimal carry-in. It produces a packed BCD sum of the same width and a decimal carry-out. It is purely combinational. Each digit occupies one nibble, with digit 0 in the least significant nibble. Both operands are assumed to hold valid BCD codes only, so every nibble is in the range 0 to 9.

The adder works in three stages. In the first stage, every digit forms its own 5-bit binary sum of the two operand nibbles, without any incoming carry. From that sum it derives two flags:
- a generate flag, raised when the sum is above nine;
- a propagate flag, raised when the sum is exactly nine.

In the second stage, a logarithmic-depth parallel-prefix tree combines these flag pairs with the external carry-in. The tree delivers the incoming decimal carry of every digit at once, with no digit waiting on the digit below it. In the third stage, each digit independently adds its incoming carry to its raw sum and adds six whenever that digit overflows past nine.

The block holds no state, so it has no states or transitions; the result follows the inputs directly.

Top module: `bcd_cla_adder`

## Requirements
- R1: Each sum nibble i (bits 4i+3..4i) equals (a_i + b_i + c_i) mod 10. Here a_i and b_i are the operand nibbles and c_i is the decimal carry into digit i.
- R2: The decimal carry out of digit i is 1 exactly when a_i + b_i + c_i exceeds 9.
- R3: The carry into digit 0 is the `carry_in` port, and `carry_out` is the carry out of the most significant digit.
- R4: For valid BCD operands, every sum nibble is a valid BCD code in the range 0000 to 1001.
- R5: When every operand digit pair sums to 9 and `carry_in` is 1, the carry propagates through all digits. The sum is all zeros and `carry_out` is 1.
- R6: When every digit pair sums to 9 and `carry_in` is 0, no carry is created. Every sum digit is 9 and `carry_out` is 0.
- R7: A carry generated in a low digit passes through every higher digit whose pair sums to 9, and it reaches `carry_out`.
- R8: The value of `carry_out`·10^N plus the decoded sum equals the decoded a plus the decoded b plus `carry_in`, where N is the digit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4*NUM_DIGITS | First packed BCD operand, digit 0 in bits 3..0 |
| opb | input | 4*NUM_DIGITS | Second packed BCD operand |
| carry_in | input | 1 | Decimal carry into digit 0 |
| sum | output | 4*NUM_DIGITS | Packed BCD sum |
| carry_out | output | 1 | Decimal carry out of the top digit |

## Verification
The bench targets the two carry corner cases. The first is a long chain of digits summing to exactly nine, with and without an incoming carry. A prefix tree that mixes up generate and propagate would either invent a carry or drop one across the chain. The second is the boundary raw sums of 9, 10 and 18 plus carry. A wrong correction condition would leave a non-BCD nibble such as 1010, or would skip the six that turns 16 into 6. An exhaustive sweep of digit 0 and a pseudo-random sweep of whole operands compare the result against integer arithmetic. These sweeps catch carries that land on the wrong digit.

// File: rtl/bcd_cla_pkg.sv
package bcd_cla_pkg;
    localparam int DIGIT_W = 4;
    localparam int RAW_W   = DIGIT_W + 1;
    localparam logic [RAW_W-1:0] DIGIT_NINE = 5'd9;
    localparam logic [DIGIT_W-1:0] SIX = 4'd6;
    typedef logic [DIGIT_W-1:0] bcd_digit_t;
    typedef logic [RAW_W-1:0]   raw_sum_t;
endpackage

// File: rtl/bcd_digit_analyzer.sv
module bcd_digit_analyzer
    import bcd_cla_pkg::*;
(
    input  bcd_digit_t a,
    input  bcd_digit_t b,
    output raw_sum_t   raw,
    output logic       dgen,
    output logic       dprop
);
    always_comb begin
        raw   = {1'b0, a} + {1'b0, b};
        // overflow past nine: binary carry, or 8-weight with 4 or 2 weight
        dgen  = raw[4] | (raw[3] & raw[2]) | (raw[3] & raw[1]);
        dprop = (raw == DIGIT_NINE);
    end
endmodule

// File: rtl/bcd_prefix_carry.sv
module bcd_prefix_carry #(
    parameter int NUM_DIGITS = 4
) (
    input  logic                  cin,
    input  logic [NUM_DIGITS-1:0] dgen,
    input  logic [NUM_DIGITS-1:0] dprop,
    output logic [NUM_DIGITS-1:0] digit_cin,
    output logic                  carry_out
);
    localparam int W      = NUM_DIGITS + 1;
    localparam int LEVELS = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] g_fin;

    always_comb begin
        logic [W-1:0] g_cur, p_cur, g_nxt, p_nxt;
        g_cur = {dgen, cin};
        p_cur = {dprop, 1'b0};
        for (int l = 0; l < LEVELS; l++) begin
            for (int j = 0; j < W; j++) begin
                if (j >= (1 << l)) begin
                    g_nxt[j] = g_cur[j] | (p_cur[j] & g_cur[j - (1 << l)]);
                    p_nxt[j] = p_cur[j] & p_cur[j - (1 << l)];
                end else begin
                    g_nxt[j] = g_cur[j];
                    p_nxt[j] = p_cur[j];
                end
            end
            g_cur = g_nxt;
            p_cur = p_nxt;
        end
        g_fin = g_cur;
    end

    assign digit_cin = g_fin[NUM_DIGITS-1:0];
    assign carry_out = g_fin[NUM_DIGITS];
endmodule

// File: rtl/bcd_digit_correct.sv
module bcd_digit_correct
    import bcd_cla_pkg::*;
(
    input  raw_sum_t   raw,
    input  logic       cin,
    input  logic       dgen,
    input  logic       dprop,
    output bcd_digit_t sum_digit
);
    always_comb begin
        raw_sum_t total;
        logic     fix;
        total     = raw + {4'd0, cin};
        fix       = dgen | (dprop & cin);
        sum_digit = fix ? (total[DIGIT_W-1:0] + SIX) : total[DIGIT_W-1:0];
    end
endmodule

// File: rtl/bcd_cla_adder.sv
module bcd_cla_adder
    import bcd_cla_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  logic [DIGIT_W*NUM_DIGITS-1:0] opa,
    input  logic [DIGIT_W*NUM_DIGITS-1:0] opb,
    input  logic                          carry_in,
    output logic [DIGIT_W*NUM_DIGITS-1:0] sum,
    output logic                          carry_out
);
    logic [NUM_DIGITS-1:0]       dgen, dprop, digit_cin;
    logic [RAW_W*NUM_DIGITS-1:0] digit_raw;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_an
        bcd_digit_analyzer u_an (
            .a     (opa[g*DIGIT_W +: DIGIT_W]),
            .b     (opb[g*DIGIT_W +: DIGIT_W]),
            .raw   (digit_raw[g*RAW_W +: RAW_W]),
            .dgen  (dgen[g]),
            .dprop (dprop[g])
        );
    end

    bcd_prefix_carry #(.NUM_DIGITS(NUM_DIGITS)) u_pfx (
        .cin       (carry_in),
        .dgen      (dgen),
        .dprop     (dprop),
        .digit_cin (digit_cin),
        .carry_out (carry_out)
    );

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_cor
        bcd_digit_correct u_cor (
            .raw       (digit_raw[g*RAW_W +: RAW_W]),
            .cin       (digit_cin[g]),
            .dgen      (dgen[g]),
            .dprop     (dprop[g]),
            .sum_digit (sum[g*DIGIT_W +: DIGIT_W])
        );
    end
endmodule

// File: rtl/bcd_cla_adder_chk.sv
module bcd_cla_adder_chk #(
    parameter int NUM_DIGITS = 4
) (
    input logic [4*NUM_DIGITS-1:0] opa,
    input logic [4*NUM_DIGITS-1:0] opb,
    input logic                    carry_in,
    input logic [4*NUM_DIGITS-1:0] sum,
    input logic                    carry_out,
    input logic [NUM_DIGITS-1:0]   digit_cin
);
    always_comb begin
        AST_CIN_LINK: assert (digit_cin[0] == carry_in); // R3
        for (int i = 0; i < NUM_DIGITS; i++) begin
            logic [4:0] tot;
            logic [4:0] md;
            tot = {1'b0, opa[4*i +: 4]} + {1'b0, opb[4*i +: 4]} + {4'd0, digit_cin[i]};
            md  = (tot > 5'd9) ? tot - 5'd10 : tot;
            AST_DIGIT_VALUE: assert (sum[4*i +: 4] == md[3:0]); // R1
            AST_DIGIT_VALID: assert (sum[4*i +: 4] <= 4'd9); // R4
            if (i < NUM_DIGITS - 1) begin
                AST_CARRY_RULE: assert (digit_cin[(i + 1) % NUM_DIGITS] == (tot > 5'd9)); // R2
            end else begin
                AST_COUT_LINK: assert (carry_out == (tot > 5'd9)); // R3
            end
        end
    end
endmodule

bind bcd_cla_adder bcd_cla_adder_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .digit_cin (digit_cin)
);

// File: tb/test_bcd_cla_adder.sv
module test_bcd_cla_adder;
    localparam int N = 4;

    logic clk = 1'b0;
    logic [4*N-1:0] opa, opb, sum;
    logic carry_in, carry_out;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bcd_cla_adder #(.NUM_DIGITS(N)) i_bcd_cla_adder (
        .opa(opa), .opb(opb), .carry_in(carry_in),
        .sum(sum), .carry_out(carry_out)
    );

    function automatic int bcd2int(input logic [4*N-1:0] v);
        int r = 0;
        for (int i = N - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [4*N-1:0] int2bcd(input int v);
        logic [4*N-1:0] r = '0;
        int t = v;
        for (int i = 0; i < N; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic apply(input logic [4*N-1:0] a, input logic [4*N-1:0] b, input logic c);
        @(posedge clk);
        opa = a; opb = b; carry_in = c;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [4*N-1:0] es, input logic ec);
        checks++;
        if (sum !== es || carry_out !== ec) begin
            failures++;
            $display("FAIL %s: a=%h b=%h ci=%b got sum=%h co=%b expected sum=%h co=%b",
                     req, opa, opb, carry_in, sum, carry_out, es, ec);
        end
    endtask

    task automatic expect_int(input string req);
        int tot = bcd2int(opa) + bcd2int(opb) + int'(carry_in);
        expect_out(req, int2bcd(tot % 10000), logic'(tot >= 10000));
    endtask

    task automatic t_reset_state;
        apply('0, '0, 1'b0);
        expect_out("R3 zero inputs", 16'h0000, 1'b0);
        apply('0, '0, 1'b1);
        expect_out("R3 carry_in into digit 0", 16'h0001, 1'b0);
    endtask

    task automatic t_basic;
        apply(16'h1234, 16'h4321, 1'b0);
        expect_out("R1 no carries", 16'h5555, 1'b0);
        apply(16'h0005, 16'h0005, 1'b0);
        expect_out("R2 raw 10 carries", 16'h0010, 1'b0);
        apply(16'h0009, 16'h0009, 1'b1);
        expect_out("R2 raw 18 plus carry", 16'h0019, 1'b0);
        apply(16'h0008, 16'h0008, 1'b0);
        expect_out("R1 raw 16 corrected", 16'h0016, 1'b0);
    endtask

    task automatic t_full_prop;
        apply(16'h9999, 16'h0000, 1'b1);
        expect_out("R5 all nines plus carry", 16'h0000, 1'b1);
        apply(16'h4536, 16'h5463, 1'b1);
        expect_out("R5 mixed pairs of nine plus carry", 16'h0000, 1'b1);
    endtask

    task automatic t_no_prop;
        apply(16'h9999, 16'h0000, 1'b0);
        expect_out("R6 all nines no carry", 16'h9999, 1'b0);
        apply(16'h2718, 16'h7281, 1'b0);
        expect_out("R6 mixed pairs of nine no carry", 16'h9999, 1'b0);
    endtask

    task automatic t_gen_ripple;
        apply(16'h0995, 16'h9005, 1'b0);
        expect_out("R7 generate through nines to top", 16'h0000, 1'b1);
        apply(16'h4507, 16'h5494, 1'b0);
        expect_out("R7 generate at digit 0", 16'h0001, 1'b1);
        apply(16'h9999, 16'h9999, 1'b1);
        expect_out("R7 all generate", 16'h9999, 1'b1);
    endtask

    task automatic t_digit0_sweep;
        for (int a = 0; a < 10; a++)
            for (int b = 0; b < 10; b++)
                for (int c = 0; c < 2; c++) begin
                    apply(16'(a), 16'(b), 1'(c));
                    expect_int("R1 R2 R4 digit 0 sweep");
                end
    endtask

    task automatic t_random_sweep;
        int seed = 12345;
        for (int k = 0; k < 600; k++) begin
            int x, y;
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            x = (seed >> 8) % 10000;
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            y = (seed >> 8) % 10000;
            apply(int2bcd(x), int2bcd(y), 1'(k & 1));
            expect_int("R8 R4 random operands");
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        opa = '0; opb = '0; carry_in = 1'b0;
        t_reset_state();
        t_basic();
        t_full_prop();
        t_no_prop();
        t_gen_ripple();
        t_digit0_sweep();
        t_random_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule